// File: doc/BRIEF.md
# Four-Slot Fetch Translation Cache with Pairwise-Order Replacement

This block is a small, fully associative translation cache for instruction fetch. It holds four page entries. Each entry has a virtual page number, a physical page number, a page-size code, an 8-bit address-space tag, a shared flag and a valid flag. A lookup compares the fetch address against all four slots in the same cycle. It reports a single hit with its translated physical address, a miss, or a multiple hit when more than one slot claims the address.

Replacement order lives in a 6-bit pairwise-order field. The field sits in the upper six bits of an 8-bit control byte, and that byte can be read and written like a register. Each slot has its own fixed pair of set and clear masks. These masks mark the slot most recently used after a hit or after a refill.

When the fetch path misses, a larger translation store outside this block returns an entry on the refill port. The block decodes the order field to pick a victim slot, writes the whole entry there, and marks that slot most recently used, all on one clock edge. An order field that decodes to no victim sends the refill to slot 0 and latches a sticky error flag.

Top module: `fetch_tlb4`

## Requirements
- R1: After synchronous reset every slot is invalid, so any lookup misses. `ctl_rdata` reads 0x00, `lru_err` is 0, and `rf_slot` reads 3.
- R2: A slot takes part in a match only when its valid flag is set. Its tag must also pass: the slot is shared, or `lk_asid_chk` is 0, or the slot's 8-bit tag equals `lk_asid`. A refill with `rf_vld`=0 leaves an entry that never matches.
- R3: Page-size code 0, 1, 2 or 3 selects a 1 KB, 4 KB, 64 KB or 1 MB page. The stored page number (address bits 31:10) is compared only above the page offset, so its lower bits inside a larger page are ignored. On a hit, `lk_paddr` takes the stored physical page bits above the offset and the fetch address bits below it.
- R4: With `lk_valid`=1, exactly one of `lk_hit`, `lk_miss` and `lk_multi` is high. `lk_multi` is high when two or more slots match, and it leaves the order field unchanged. With `lk_valid`=0, all three are low. The result is combinational in the same cycle.
- R5: A hit updates the order field on the next clock edge. In `ctl_rdata`, bit 7 stands for order bit 31 and so on down to bit 2 for order bit 26. Slot 0 clears bits 31, 30 and 29. Slot 1 sets 31 and clears 28 and 27. Slot 2 sets 30 and 28 and clears 26. Slot 3 sets 29, 27 and 26. Bits 1:0 of the control byte never change through these updates.
- R6: `rf_slot` shows the victim, decoded combinationally from the current field and tried in order 0 to 3. The victim is 0 if bits 31..29 are all 1. It is 1 if bit 31 is 0 and bits 28 and 27 are 1. It is 2 if bits 30 and 28 are 0 and bit 26 is 1. It is 3 if bits 29, 27 and 26 are all 0.
- R7: With `rf_valid`=1, the whole entry is written into the victim slot on the clock edge. On the same edge the order field is updated with that slot's masks.
- R8: With `ctl_we`=1, `ctl_wdata` replaces the whole control byte on the edge. This takes priority over any hit or refill update of the field in that cycle, although a refill still writes its entry.
- R9: If the field matches none of the four patterns, `rf_slot` reads 0. A refill in that state sets `lru_err`, which stays high until reset.
- R10: When a hit and a refill occur in the same cycle, the lookup sees the entries as they were before the edge. The refill's update of the order field wins over the hit's.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vaddr | input | 32 | Fetch virtual address |
| lk_asid | input | 8 | Current address-space tag |
| lk_asid_chk | input | 1 | 1 = compare address-space tags |
| lk_hit | output | 1 | Exactly one slot matched |
| lk_miss | output | 1 | No slot matched |
| lk_multi | output | 1 | Two or more slots matched |
| lk_slot | output | 2 | Matching slot on a hit |
| lk_paddr | output | 29 | Translated physical address on a hit, else 0 |
| rf_valid | input | 1 | Write refill entry into the victim slot |
| rf_vpn | input | 22 | Refill virtual page number (address bits 31:10) |
| rf_asid | input | 8 | Refill address-space tag |
| rf_ppn | input | 19 | Refill physical page number (bits 28:10) |
| rf_size | input | 2 | Refill page-size code |
| rf_shared | input | 1 | Refill shared flag |
| rf_vld | input | 1 | Refill valid flag |
| rf_slot | output | 2 | Current victim slot |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write data |
| ctl_rdata | output | 8 | Control byte (bits 7:2 = order field) |
| lru_err | output | 1 | Sticky illegal-order-state flag |

## Verification
The bench builds the block with its package widths: a 32-bit virtual address, a 29-bit physical address and an 8-bit tag. With these widths one test run can reach all four page sizes, the shared flag, and tag mismatch with checking on and off. The 6-bit order field is small enough to force every victim pattern through control writes, along with an illegal pattern. The refill sequence from reset walks the victim order through all four slots. Deliberate overlapping entries bring the multiple-hit case within reach, and same-cycle collisions of hit, refill and control write cover the priority rules.

// File: rtl/ftlb_pkg.sv
package ftlb_pkg;
    localparam int VA_W   = 32;
    localparam int PA_W   = 29;
    localparam int ASID_W = 8;
    localparam int PG_LSB = 10;
    localparam int NSLOT  = 4;
    localparam int ORD_W  = 6;
    localparam int CTL_W  = 8;
    localparam int VPN_W  = VA_W - PG_LSB;
    localparam int PPN_W  = PA_W - PG_LSB;
    localparam int SLOT_W = $clog2(NSLOT);

    typedef logic [SLOT_W-1:0] slot_t;
    typedef logic [ORD_W-1:0]  order_t;

    typedef enum logic [1:0] {
        PG_1K  = 2'd0,
        PG_4K  = 2'd1,
        PG_64K = 2'd2,
        PG_1M  = 2'd3
    } pgsz_e;

    typedef struct packed {
        logic              vld;
        logic              shr;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        logic [PPN_W-1:0]  ppn;
        pgsz_e             size;
    } tlb_ent_t;

    // number of page-number bits that fall inside the page offset
    function automatic int unsigned pg_extra(pgsz_e s);
        case (s)
            PG_1K:   return 0;
            PG_4K:   return 2;
            PG_64K:  return 6;
            default: return 10;
        endcase
    endfunction

    // order-field bit 5 maps to control bit 31, bit 0 to control bit 26
    function automatic order_t ord_touch(order_t st, slot_t s);
        case (s)
            2'd0:    return st & 6'b000111;
            2'd1:    return (st & 6'b111001) | 6'b100000;
            2'd2:    return (st & 6'b111110) | 6'b010100;
            default: return st | 6'b001011;
        endcase
    endfunction

    // returns {illegal, victim}
    function automatic logic [SLOT_W:0] ord_pick(order_t st);
        if (st[5:3] == 3'b111)                 return {1'b0, 2'd0};
        else if (!st[5] && st[2] && st[1])     return {1'b0, 2'd1};
        else if (!st[4] && !st[2] && st[0])    return {1'b0, 2'd2};
        else if (!st[3] && !st[1] && !st[0])   return {1'b0, 2'd3};
        else                                   return {1'b1, 2'd0};
    endfunction
endpackage

// File: rtl/ftlb_way.sv
module ftlb_way
    import ftlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  tlb_ent_t          wr_ent,
    input  logic [VA_W-1:0]   va,
    input  logic [ASID_W-1:0] asid,
    input  logic              asid_chk,
    output logic              match,
    output logic [PA_W-1:0]   pa
);
    tlb_ent_t         ent;
    logic [VPN_W-1:0] keep;
    logic             tag_ok;

    always_ff @(posedge clk) begin
        if (rst)        ent <= '0;
        else if (wr_en) ent <= wr_ent;
    end

    always_comb begin
        keep   = {VPN_W{1'b1}} << pg_extra(ent.size);
        tag_ok = ent.shr | ~asid_chk | (ent.asid == asid);
        match  = ent.vld & tag_ok &
                 (((va[VA_W-1:PG_LSB] ^ ent.vpn) & keep) == '0);
        pa     = {(ent.ppn & keep[PPN_W-1:0]) |
                  (va[PA_W-1:PG_LSB] & ~keep[PPN_W-1:0]),
                  va[PG_LSB-1:0]};
    end
endmodule

// File: rtl/ftlb_order.sv
module ftlb_order
    import ftlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wd,
    input  logic             touch_en,
    input  slot_t            touch_slot,
    input  logic             fill_en,
    output logic [CTL_W-1:0] ctl_q,
    output slot_t            victim,
    output logic             err
);
    localparam int KEEP_W = CTL_W - ORD_W;

    logic [CTL_W-1:0] ctl_r;
    logic             bad;
    order_t           cur;

    assign cur           = ctl_r[CTL_W-1:KEEP_W];
    assign {bad, victim} = ord_pick(cur);
    assign ctl_q         = ctl_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_r <= '0;
            err   <= 1'b0;
        end else begin
            if (ctl_we)
                ctl_r <= ctl_wd;
            else if (fill_en)
                ctl_r <= {ord_touch(cur, victim), ctl_r[KEEP_W-1:0]};
            else if (touch_en)
                ctl_r <= {ord_touch(cur, touch_slot), ctl_r[KEEP_W-1:0]};
            if (fill_en && bad)
                err <= 1'b1;
        end
    end
endmodule

// File: rtl/fetch_tlb4.sv
module fetch_tlb4
    import ftlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_asid_chk,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic              lk_multi,
    output logic [SLOT_W-1:0] lk_slot,
    output logic [PA_W-1:0]   lk_paddr,
    input  logic              rf_valid,
    input  logic [VPN_W-1:0]  rf_vpn,
    input  logic [ASID_W-1:0] rf_asid,
    input  logic [PPN_W-1:0]  rf_ppn,
    input  logic [1:0]        rf_size,
    input  logic              rf_shared,
    input  logic              rf_vld,
    output logic [SLOT_W-1:0] rf_slot,
    input  logic              ctl_we,
    input  logic [CTL_W-1:0]  ctl_wdata,
    output logic [CTL_W-1:0]  ctl_rdata,
    output logic              lru_err
);
    logic [NSLOT-1:0] hits;
    logic [PA_W-1:0]  way_pa [NSLOT];
    tlb_ent_t         fill_ent;
    slot_t            victim;
    slot_t            sel;
    int unsigned      nhit;

    assign fill_ent = '{vld: rf_vld, shr: rf_shared, asid: rf_asid,
                        vpn: rf_vpn, ppn: rf_ppn, size: pgsz_e'(rf_size)};

    for (genvar g = 0; g < NSLOT; g++) begin : g_way
        ftlb_way u_way (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (rf_valid && (victim == slot_t'(g))),
            .wr_ent   (fill_ent),
            .va       (lk_vaddr),
            .asid     (lk_asid),
            .asid_chk (lk_asid_chk),
            .match    (hits[g]),
            .pa       (way_pa[g])
        );
    end

    always_comb begin
        nhit = $countones(hits);
        sel  = '0;
        for (int i = NSLOT - 1; i >= 0; i--)
            if (hits[i]) sel = slot_t'(i);
        lk_hit   = lk_valid && (nhit == 1);
        lk_miss  = lk_valid && (nhit == 0);
        lk_multi = lk_valid && (nhit > 1);
        lk_slot  = lk_hit ? sel : '0;
        lk_paddr = lk_hit ? way_pa[sel] : '0;
    end

    ftlb_order u_order (
        .clk        (clk),
        .rst        (rst),
        .ctl_we     (ctl_we),
        .ctl_wd     (ctl_wdata),
        .touch_en   (lk_hit),
        .touch_slot (sel),
        .fill_en    (rf_valid),
        .ctl_q      (ctl_rdata),
        .victim     (victim),
        .err        (lru_err)
    );

    assign rf_slot = victim;
endmodule

// File: rtl/fetch_tlb4_chk.sv
module fetch_tlb4_chk
    import ftlb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              lk_valid,
    input logic              lk_hit,
    input logic              lk_miss,
    input logic              lk_multi,
    input logic [SLOT_W-1:0] lk_slot,
    input logic              rf_valid,
    input logic [SLOT_W-1:0] rf_slot,
    input logic              ctl_we,
    input logic [CTL_W-1:0]  ctl_wdata,
    input logic [CTL_W-1:0]  ctl_rdata,
    input logic              lru_err
);
    a_r4_one_result: assert property (@(posedge clk) disable iff (rst)
        lk_valid |-> $onehot({lk_hit, lk_miss, lk_multi}));

    a_r4_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |-> !(lk_hit || lk_miss || lk_multi));

    a_r5_low_bits_kept: assert property (@(posedge clk) disable iff (rst)
        !ctl_we |=> $stable(ctl_rdata[1:0]));

    a_r5_touch_slot0: assert property (@(posedge clk) disable iff (rst)
        (lk_hit && lk_slot == 2'd0 && !rf_valid && !ctl_we)
        |=> (ctl_rdata[7:5] == 3'b000));

    a_r5_touch_slot3: assert property (@(posedge clk) disable iff (rst)
        (lk_hit && lk_slot == 2'd3 && !rf_valid && !ctl_we)
        |=> (ctl_rdata[5] && ctl_rdata[3] && ctl_rdata[2]));

    a_r7_fill_slot1_mru: assert property (@(posedge clk) disable iff (rst)
        (rf_valid && rf_slot == 2'd1 && !ctl_we)
        |=> (ctl_rdata[7] && !ctl_rdata[4] && !ctl_rdata[3]));

    a_r8_write_wins: assert property (@(posedge clk) disable iff (rst)
        ctl_we |=> (ctl_rdata == $past(ctl_wdata)));

    a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
        lru_err |=> lru_err);
endmodule

bind fetch_tlb4 fetch_tlb4_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .lk_valid  (lk_valid),
    .lk_hit    (lk_hit),
    .lk_miss   (lk_miss),
    .lk_multi  (lk_multi),
    .lk_slot   (lk_slot),
    .rf_valid  (rf_valid),
    .rf_slot   (rf_slot),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .ctl_rdata (ctl_rdata),
    .lru_err   (lru_err)
);

// File: tb/fetch_tlb4_tb_top.sv
module fetch_tlb4_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 0;
    logic [31:0] lk_vaddr = 0;
    logic [7:0]  lk_asid = 0;
    logic        lk_asid_chk = 1;
    logic        lk_hit, lk_miss, lk_multi;
    logic [1:0]  lk_slot;
    logic [28:0] lk_paddr;
    logic        rf_valid = 0;
    logic [21:0] rf_vpn = 0;
    logic [7:0]  rf_asid = 0;
    logic [18:0] rf_ppn = 0;
    logic [1:0]  rf_size = 0;
    logic        rf_shared = 0;
    logic        rf_vld = 0;
    logic [1:0]  rf_slot;
    logic        ctl_we = 0;
    logic [7:0]  ctl_wdata = 0;
    logic [7:0]  ctl_rdata;
    logic        lru_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    fetch_tlb4 dut_i (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_asid(lk_asid),
        .lk_asid_chk(lk_asid_chk), .lk_hit(lk_hit), .lk_miss(lk_miss),
        .lk_multi(lk_multi), .lk_slot(lk_slot), .lk_paddr(lk_paddr),
        .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_asid(rf_asid),
        .rf_ppn(rf_ppn), .rf_size(rf_size), .rf_shared(rf_shared),
        .rf_vld(rf_vld), .rf_slot(rf_slot),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .lru_err(lru_err)
    );

    // behavioural reference state
    bit          m_vld [4];
    bit          m_shr [4];
    int unsigned m_asid[4];
    int unsigned m_va  [4];
    int unsigned m_pa  [4];
    int unsigned m_sz  [4];
    bit [31:0]   m_word;   // control bits 31..24
    bit          m_err;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic bit [31:0] page_mask(int unsigned sz);
        int unsigned bits;
        bits = (sz == 0) ? 10 : (sz == 1) ? 12 : (sz == 2) ? 16 : 20;
        return 32'hFFFF_FFFF << bits;
    endfunction

    function automatic bit ref_match(int i);
        bit [31:0] m;
        m = page_mask(m_sz[i]);
        return m_vld[i] && (m_shr[i] || !lk_asid_chk || m_asid[i] == lk_asid)
               && ((lk_vaddr & m) == (m_va[i] & m));
    endfunction

    // returns victim in [1:0], illegal flag in bit 2
    function automatic int ref_victim();
        bit [31:0] w;
        w = m_word;
        if (w[31] && w[30] && w[29])         return 0;
        if (!w[31] && w[28] && w[27])        return 1;
        if (!w[30] && !w[28] && w[26])       return 2;
        if (!w[29] && !w[27] && !w[26])      return 3;
        return 4;
    endfunction

    function automatic void ref_use(int s);
        case (s)
            0: m_word = m_word & ~(32'h1 << 31) & ~(32'h1 << 30) & ~(32'h1 << 29);
            1: m_word = (m_word | (32'h1 << 31)) & ~(32'h1 << 28) & ~(32'h1 << 27);
            2: m_word = (m_word | (32'h1 << 30) | (32'h1 << 28)) & ~(32'h1 << 26);
            default: m_word = m_word | (32'h1 << 29) | (32'h1 << 27) | (32'h1 << 26);
        endcase
    endfunction

    // inputs already applied; compare at negedge, then advance model and clock
    task automatic tick(string tag);
        int nm, ms, vraw, vic;
        bit e_hit;
        bit [31:0] pm, epa;
        @(negedge clk);
        nm = 0; ms = 0;
        for (int i = 0; i < 4; i++)
            if (ref_match(i)) begin nm++; ms = i; end
        e_hit = lk_valid && nm == 1;
        chk(tag, "hit",   {31'd0, lk_hit},   {31'd0, e_hit});
        chk(tag, "miss",  {31'd0, lk_miss},  {31'd0, lk_valid && nm == 0});
        chk(tag, "multi", {31'd0, lk_multi}, {31'd0, lk_valid && nm > 1});
        if (e_hit) begin
            pm  = page_mask(m_sz[ms]);
            epa = ((m_pa[ms] & pm) | (lk_vaddr & ~pm)) & 32'h1FFF_FFFF;
            chk(tag, "slot",  {30'd0, lk_slot}, ms);
            chk(tag, "paddr", {3'd0, lk_paddr}, epa);
        end
        vraw = ref_victim();
        vic  = (vraw == 4) ? 0 : vraw;
        chk(tag, "victim", {30'd0, rf_slot}, vic);
        chk(tag, "ctl", {24'd0, ctl_rdata}, {24'd0, m_word[31:24]});
        chk(tag, "err", {31'd0, lru_err}, {31'd0, m_err});
        // model advance
        if (rf_valid && vraw == 4) m_err = 1;
        if (ctl_we)        m_word = {ctl_wdata, 24'd0};
        else if (rf_valid) ref_use(vic);
        else if (e_hit)    ref_use(ms);
        if (rf_valid) begin
            m_vld[vic]  = rf_vld;
            m_shr[vic]  = rf_shared;
            m_asid[vic] = rf_asid;
            m_va[vic]   = {rf_vpn, 10'd0};
            m_pa[vic]   = {3'd0, rf_ppn, 10'd0};
            m_sz[vic]   = rf_size;
        end
        @(posedge clk);
        #1;
        lk_valid = 0; rf_valid = 0; ctl_we = 0; lk_asid_chk = 1;
    endtask

    task automatic look(string tag, logic [31:0] va, logic [7:0] asid, bit chk_on);
        lk_valid = 1; lk_vaddr = va; lk_asid = asid; lk_asid_chk = chk_on;
        tick(tag);
    endtask

    task automatic set_fill(logic [31:0] va, logic [7:0] asid, logic [31:0] pa,
                            logic [1:0] sz, bit sh, bit v);
        rf_valid = 1; rf_vpn = va[31:10]; rf_asid = asid; rf_ppn = pa[28:10];
        rf_size = sz; rf_shared = sh; rf_vld = v;
    endtask

    task automatic fill(string tag, logic [31:0] va, logic [7:0] asid, logic [31:0] pa,
                        logic [1:0] sz, bit sh, bit v);
        set_fill(va, asid, pa, sz, sh, v);
        tick(tag);
    endtask

    task automatic wr_ctl(string tag, logic [7:0] d);
        ctl_we = 1; ctl_wdata = d;
        tick(tag);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_vld[i] = 0; m_shr[i] = 0; m_asid[i] = 0;
            m_va[i] = 0; m_pa[i] = 0; m_sz[i] = 0;
        end
        m_word = 0; m_err = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R1: reset state, empty cache misses
        tick("R1");
        look("R1", 32'h0040_0000, 8'd5, 1);

        // R7: refills walk the victim order from reset (3,2,1,0)
        fill("R7", 32'h0040_0000, 8'd5, 32'h0010_0000, 2'd0, 0, 1);
        fill("R7", 32'h0100_0000, 8'd9, 32'h0123_0000, 2'd2, 1, 1);
        fill("R3", 32'h0208_0400, 8'd7, 32'h0350_0000, 2'd3, 0, 1);
        fill("R6", 32'h0300_1000, 8'd5, 32'h0000_2000, 2'd1, 0, 1);

        // R3: page extents and translation
        look("R3", 32'h0040_03FC, 8'd5, 1);
        look("R3", 32'h0040_0400, 8'd5, 1);
        look("R3", 32'h020F_FFFC, 8'd7, 1);
        look("R3", 32'h0200_0000, 8'd7, 1);
        look("R3", 32'h0300_1FFF, 8'd5, 1);
        look("R3", 32'h0300_2000, 8'd5, 1);
        look("R3", 32'h0100_FFF0, 8'd9, 1);

        // R2: tag checking, shared flag
        look("R2", 32'h0040_0010, 8'd6, 1);
        look("R2", 32'h0040_0010, 8'd6, 0);
        look("R2", 32'h0100_0004, 8'd1, 1);

        // R4: no request, no result
        lk_valid = 0; lk_vaddr = 32'h0040_0000; tick("R4");

        // R10: hit and refill together; refill is an invalid entry
        lk_valid = 1; lk_vaddr = 32'h0300_1004; lk_asid = 8'd5;
        set_fill(32'h0500_0000, 8'd5, 32'h0000_4000, 2'd1, 0, 0);
        tick("R10");
        look("R2", 32'h0500_0000, 8'd5, 1);

        // R8: control write beats a hit in the same cycle
        lk_valid = 1; lk_vaddr = 32'h0100_0000; lk_asid = 8'd9;
        ctl_we = 1; ctl_wdata = 8'h03;
        tick("R8");
        // R5: hits keep control bits 1:0
        look("R5", 32'h0040_0000, 8'd5, 1);
        look("R5", 32'h0100_0010, 8'd2, 1);
        look("R5", 32'h0300_1010, 8'd5, 1);
        tick("R5");

        // R4: overlapping entry gives multiple hit, order unchanged
        wr_ctl("R6", 8'h07);
        fill("R4", 32'h0040_0800, 8'd5, 32'h0060_0000, 2'd1, 0, 1);
        wr_ctl("R4", 8'h50);
        look("R4", 32'h0040_0100, 8'd5, 1);
        tick("R4");

        // R6: forced victim patterns
        wr_ctl("R6", 8'hE0); tick("R6");
        wr_ctl("R6", 8'h18); tick("R6");
        wr_ctl("R6", 8'h04); tick("R6");
        wr_ctl("R6", 8'h00); tick("R6");

        // R9: illegal state, refill to slot 0, sticky flag
        wr_ctl("R9", 8'h94);
        tick("R9");
        fill("R9", 32'h0700_0000, 8'd3, 32'h0070_0000, 2'd1, 0, 1);
        look("R9", 32'h0700_0ABC, 8'd3, 1);
        wr_ctl("R9", 8'h00);
        tick("R9");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule